// File: doc/BRIEF.md
# Raster Slot and Line Counter

This block produces the horizontal and vertical position of a tile-based video controller. It advances once per memory access slot. An 8-bit slot counter steps through each scan line. A 9-bit line counter steps once per line and does not count straight through: both counters jump over a range of values, which gives the uneven sequences that the rest of the controller decodes.

The width select picks the wide (40-cell) or narrow (32-cell) slot sequence. The mode select, the region input and the latched 50 Hz bit together pick one of six vertical timing profiles. Each profile sets the first blanked line and the line where the counter jumps to a high value. The outputs are the current slot and line, a strobe in the cycle a new line value appears, a strobe in the cycle the first blanked line appears, and a flag that marks slots where the display fetches pattern data.

Timing profiles (`vprof_e`), selected without state from the inputs:

- `PROF_M5_NTSC`: mode 5, 60 Hz region.
- `PROF_M5_LONG`: mode 5, 60 Hz region with the 50 Hz bit set.
- `PROF_M5_PAL28`: mode 5, 50 Hz region, 28-row.
- `PROF_M5_PAL30`: mode 5, 50 Hz region, 30-row.
- `PROF_M4_NTSC`: mode 4, 60 Hz region.
- `PROF_M4_PAL`: mode 4, 50 Hz region.

Line transitions:

- Step: the line goes up by one.
- Jump: the line goes from the jump line to a high value.
- Wrap: the line goes from 0x1FF to 0.

Top module: `raster_scan_counter`

## Requirements
- R1: While rst_n is low, slot_o and line_o are 0, and line_adv_o and frame_o are low.
- R2: At each clock edge, slot_o goes up by one (255 wraps to 0), except at the skip slots named in R3 and R4.
- R3: With wide_i high, slot 183 is followed directly by slot 229.
- R4: With wide_i low, slot 148 is followed directly by slot 233.
- R5: line_o changes only in the cycle where slot_o takes the line-change value, and line_adv_o is high exactly in that cycle. The line-change value is 165 when wide, 133 when narrow in mode 5, and 249 when narrow in mode 4.
- R6: After line 0x1FF, the line counter wraps to 0.
- R7: In mode 5 in the 60 Hz region with the 50 Hz bit clear, line 0xEA is followed by 0x1E5. In the same region with the 50 Hz bit set, the line counter does not jump.
- R8: In mode 5 in the 50 Hz region, line 0x10B is followed by 0x1D2 when the 50 Hz bit is set, and line 0x102 is followed by 0x1CA when it is clear. No other line jumps in these profiles.
- R9: In mode 4 (m5_i low), line 0xDB is followed by 0x1D5 in the 60 Hz region, and line 0xF2 is followed by 0x1BA in the 50 Hz region.
- R10: The first blanked line is 224 in mode 5 at 60 Hz and 240 in mode 5 in the 50 Hz region with the bit set. In mode 5 in the 50 Hz region with the bit clear it is 224. In mode 5 in the 60 Hz region with the bit set, no line is blanked. In mode 5, active_o is high when disp_en_i is high and the line is below the first blanked line or equal to 0x1FF.
- R11: In mode 4, the first blanked line is 192. active_o is high only when the line is below 192, disp_en_i is high and m4_en_i is high.
- R12: frame_o pulses for exactly one cycle, together with line_adv_o, when line_o takes the value of the first blanked line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slot clock, one edge per access slot |
| rst_n | input | 1 | Synchronous active-low reset |
| wide_i | input | 1 | 1 = 40-cell slot sequence, 0 = 32-cell |
| m5_i | input | 1 | 1 = mode 5 timing, 0 = mode 4 timing |
| disp_en_i | input | 1 | Display enable |
| m4_en_i | input | 1 | Mode-4 enable bit, gates fetch outside mode 5 |
| region_pal_i | input | 1 | 1 = 50 Hz region |
| pal_i | input | 1 | Latched 50 Hz (30-row) bit |
| slot_o | output | 8 | Current slot number |
| line_o | output | 9 | Current line number |
| line_adv_o | output | 1 | High in the cycle a new line value appears |
| frame_o | output | 1 | High in the cycle line_o reaches the first blanked line |
| active_o | output | 1 | Slot is a display fetch slot |

## Verification
The jump properties compare the line before an advance with the line after it. They assume that the mode, region and 50 Hz inputs do not change in the slot where a line advance happens. The stimulus changes those inputs only in the low half of a cycle, right after a line strobe has been seen and well before the next line-change slot.

The slot properties do not assume a width setting. The skip checks apply only when wide_i is steady for that slot, and the stimulus changes wide_i only while reset is held.

// File: rtl/raster_pkg.sv
`timescale 1ns/1ps
package raster_pkg;
    localparam int SLOT_W  = 8;
    localparam int LINE_W  = 9;
    localparam int INACT_W = LINE_W + 1;

    typedef enum logic [2:0] {
        PROF_M5_NTSC,
        PROF_M5_LONG,
        PROF_M5_PAL28,
        PROF_M5_PAL30,
        PROF_M4_NTSC,
        PROF_M4_PAL
    } vprof_e;

    typedef struct packed {
        logic [INACT_W-1:0] inact_line;
        logic               jump_en;
        logic [LINE_W-1:0]  jump_from;
        logic [LINE_W-1:0]  jump_to;
    } vtiming_t;
endpackage

// File: rtl/raster_profile.sv
`timescale 1ns/1ps
module raster_profile
    import raster_pkg::*;
#(
    parameter int M5_NTSC_INACT  = 224,
    parameter int M5_NTSC_FROM   = 'h0EA,
    parameter int M5_NTSC_TO     = 'h1E5,
    parameter int M5_PAL28_INACT = 224,
    parameter int M5_PAL28_FROM  = 'h102,
    parameter int M5_PAL28_TO    = 'h1CA,
    parameter int M5_PAL30_INACT = 240,
    parameter int M5_PAL30_FROM  = 'h10B,
    parameter int M5_PAL30_TO    = 'h1D2,
    parameter int M5_LONG_INACT  = 512,
    parameter int M4_INACT       = 192,
    parameter int M4_NTSC_FROM   = 'h0DB,
    parameter int M4_NTSC_TO     = 'h1D5,
    parameter int M4_PAL_FROM    = 'h0F2,
    parameter int M4_PAL_TO      = 'h1BA
) (
    input  logic     m5_i,
    input  logic     region_pal_i,
    input  logic     pal_i,
    output vprof_e   prof_o,
    output vtiming_t tim_o
);
    // Profile decode from the mode, region and latched 50 Hz bit
    always_comb begin
        prof_o = PROF_M4_NTSC;
        if (m5_i) begin
            unique case ({region_pal_i, pal_i})
                2'b00:   prof_o = PROF_M5_NTSC;
                2'b01:   prof_o = PROF_M5_LONG;
                2'b10:   prof_o = PROF_M5_PAL28;
                default: prof_o = PROF_M5_PAL30;
            endcase
        end else begin
            prof_o = region_pal_i ? PROF_M4_PAL : PROF_M4_NTSC;
        end
    end

    // Per-profile vertical timing
    always_comb begin
        tim_o = '0;
        unique case (prof_o)
            PROF_M5_NTSC: begin
                tim_o.inact_line = INACT_W'(M5_NTSC_INACT);
                tim_o.jump_en    = 1'b1;
                tim_o.jump_from  = LINE_W'(M5_NTSC_FROM);
                tim_o.jump_to    = LINE_W'(M5_NTSC_TO);
            end
            PROF_M5_LONG: begin
                tim_o.inact_line = INACT_W'(M5_LONG_INACT);
                tim_o.jump_en    = 1'b0;
            end
            PROF_M5_PAL28: begin
                tim_o.inact_line = INACT_W'(M5_PAL28_INACT);
                tim_o.jump_en    = 1'b1;
                tim_o.jump_from  = LINE_W'(M5_PAL28_FROM);
                tim_o.jump_to    = LINE_W'(M5_PAL28_TO);
            end
            PROF_M5_PAL30: begin
                tim_o.inact_line = INACT_W'(M5_PAL30_INACT);
                tim_o.jump_en    = 1'b1;
                tim_o.jump_from  = LINE_W'(M5_PAL30_FROM);
                tim_o.jump_to    = LINE_W'(M5_PAL30_TO);
            end
            PROF_M4_NTSC: begin
                tim_o.inact_line = INACT_W'(M4_INACT);
                tim_o.jump_en    = 1'b1;
                tim_o.jump_from  = LINE_W'(M4_NTSC_FROM);
                tim_o.jump_to    = LINE_W'(M4_NTSC_TO);
            end
            PROF_M4_PAL: begin
                tim_o.inact_line = INACT_W'(M4_INACT);
                tim_o.jump_en    = 1'b1;
                tim_o.jump_from  = LINE_W'(M4_PAL_FROM);
                tim_o.jump_to    = LINE_W'(M4_PAL_TO);
            end
            default: tim_o = '0;
        endcase
    end
endmodule

// File: rtl/raster_slot_ctr.sv
`timescale 1ns/1ps
module raster_slot_ctr
    import raster_pkg::*;
#(
    parameter int WIDE_SKIP_FROM   = 183,
    parameter int WIDE_SKIP_TO     = 229,
    parameter int NARROW_SKIP_FROM = 148,
    parameter int NARROW_SKIP_TO   = 233,
    parameter int LC_WIDE          = 165,
    parameter int LC_NARROW_M5     = 133,
    parameter int LC_NARROW_M4     = 249
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wide_i,
    input  logic              m5_i,
    output logic [SLOT_W-1:0] slot_o,
    output logic              line_req_o
);
    localparam logic [SLOT_W-1:0] W_FROM  = SLOT_W'(WIDE_SKIP_FROM);
    localparam logic [SLOT_W-1:0] W_TO    = SLOT_W'(WIDE_SKIP_TO);
    localparam logic [SLOT_W-1:0] N_FROM  = SLOT_W'(NARROW_SKIP_FROM);
    localparam logic [SLOT_W-1:0] N_TO    = SLOT_W'(NARROW_SKIP_TO);
    localparam logic [SLOT_W-1:0] LCW     = SLOT_W'(LC_WIDE);
    localparam logic [SLOT_W-1:0] LCN5    = SLOT_W'(LC_NARROW_M5);
    localparam logic [SLOT_W-1:0] LCN4    = SLOT_W'(LC_NARROW_M4);

    logic [SLOT_W-1:0] skip_from, skip_to, lc_slot, slot_nxt;

    always_comb begin
        skip_from  = wide_i ? W_FROM : N_FROM;
        skip_to    = wide_i ? W_TO   : N_TO;
        lc_slot    = wide_i ? LCW : (m5_i ? LCN5 : LCN4);
        slot_nxt   = (slot_o == skip_from) ? skip_to : slot_o + 1'b1;
        line_req_o = (slot_nxt == lc_slot);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) slot_o <= '0;
        else        slot_o <= slot_nxt;
    end
endmodule

// File: rtl/raster_line_ctr.sv
`timescale 1ns/1ps
module raster_line_ctr
    import raster_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_req_i,
    input  vtiming_t          tim_i,
    output logic [LINE_W-1:0] line_o,
    output logic              line_adv_o,
    output logic              frame_o
);
    logic [LINE_W-1:0] line_inc, line_nxt;
    logic              hit_inact;

    always_comb begin
        line_inc  = line_o + 1'b1;
        line_nxt  = (tim_i.jump_en && (line_o == tim_i.jump_from)) ? tim_i.jump_to : line_inc;
        hit_inact = (INACT_W'(line_nxt) == tim_i.inact_line);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_o     <= '0;
            line_adv_o <= 1'b0;
            frame_o    <= 1'b0;
        end else begin
            if (line_req_i) line_o <= line_nxt;
            line_adv_o <= line_req_i;
            frame_o    <= line_req_i && hit_inact;
        end
    end
endmodule

// File: rtl/raster_active.sv
`timescale 1ns/1ps
module raster_active
    import raster_pkg::*;
(
    input  logic [LINE_W-1:0] line_i,
    input  vtiming_t          tim_i,
    input  logic              m5_i,
    input  logic              disp_en_i,
    input  logic              m4_en_i,
    output logic              active_o
);
    logic below, top_line;

    always_comb begin
        below    = (INACT_W'(line_i) < tim_i.inact_line);
        top_line = &line_i;
        if (m5_i) active_o = (below || top_line) && disp_en_i;
        else      active_o = below && disp_en_i && m4_en_i;
    end
endmodule

// File: rtl/raster_scan_counter.sv
`timescale 1ns/1ps
module raster_scan_counter
    import raster_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wide_i,
    input  logic              m5_i,
    input  logic              disp_en_i,
    input  logic              m4_en_i,
    input  logic              region_pal_i,
    input  logic              pal_i,
    output logic [SLOT_W-1:0] slot_o,
    output logic [LINE_W-1:0] line_o,
    output logic              line_adv_o,
    output logic              frame_o,
    output logic              active_o
);
    vprof_e   prof;
    vtiming_t tim;
    logic     line_req;

    raster_profile u_profile (
        .m5_i         (m5_i),
        .region_pal_i (region_pal_i),
        .pal_i        (pal_i),
        .prof_o       (prof),
        .tim_o        (tim)
    );

    raster_slot_ctr u_slot (
        .clk        (clk),
        .rst_n      (rst_n),
        .wide_i     (wide_i),
        .m5_i       (m5_i),
        .slot_o     (slot_o),
        .line_req_o (line_req)
    );

    raster_line_ctr u_line (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_req_i (line_req),
        .tim_i      (tim),
        .line_o     (line_o),
        .line_adv_o (line_adv_o),
        .frame_o    (frame_o)
    );

    raster_active u_active (
        .line_i    (line_o),
        .tim_i     (tim),
        .m5_i      (m5_i),
        .disp_en_i (disp_en_i),
        .m4_en_i   (m4_en_i),
        .active_o  (active_o)
    );

    logic unused_prof;
    assign unused_prof = ^prof;
endmodule

// File: rtl/raster_scan_counter_chk.sv
`timescale 1ns/1ps
module raster_scan_counter_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wide_i,
    input logic       m5_i,
    input logic       disp_en_i,
    input logic       m4_en_i,
    input logic       region_pal_i,
    input logic       pal_i,
    input logic [7:0] slot_o,
    input logic [8:0] line_o,
    input logic       line_adv_o,
    input logic       frame_o,
    input logic       active_o
);
    AST_SLOT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_o != 8'd183 && slot_o != 8'd148) |=> (slot_o == $past(slot_o) + 8'd1)); // R2
    AST_WIDE_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
        (wide_i && slot_o == 8'd183) |=> (slot_o == 8'd229)); // R3
    AST_NARROW_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
        (!wide_i && slot_o == 8'd148) |=> (slot_o == 8'd233)); // R4
    AST_LINE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !line_adv_o |-> $stable(line_o)); // R5
    AST_WIDE_LC_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        (line_adv_o && $past(wide_i)) |-> (slot_o == 8'd165)); // R5
    AST_LINE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (line_adv_o && $past(line_o) == 9'h1FF) |-> (line_o == 9'h000)); // R6
    AST_NTSC_JUMP: assert property (@(posedge clk) disable iff (!rst_n)
        (line_adv_o && $past(m5_i && !region_pal_i && !pal_i) && $past(line_o) == 9'h0EA)
        |-> (line_o == 9'h1E5)); // R7
    AST_PAL30_JUMP: assert property (@(posedge clk) disable iff (!rst_n)
        (line_adv_o && $past(m5_i && region_pal_i && pal_i) && $past(line_o) == 9'h10B)
        |-> (line_o == 9'h1D2)); // R8
    AST_NO_DISP: assert property (@(posedge clk) disable iff (!rst_n)
        !disp_en_i |-> !active_o); // R10
    AST_M4_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (!m5_i && !m4_en_i) |-> !active_o); // R11
    AST_FRAME_WITH_ADV: assert property (@(posedge clk) disable iff (!rst_n)
        frame_o |-> line_adv_o); // R12
    AST_FRAME_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        frame_o |=> !frame_o); // R12
endmodule

bind raster_scan_counter raster_scan_counter_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .wide_i       (wide_i),
    .m5_i         (m5_i),
    .disp_en_i    (disp_en_i),
    .m4_en_i      (m4_en_i),
    .region_pal_i (region_pal_i),
    .pal_i        (pal_i),
    .slot_o       (slot_o),
    .line_o       (line_o),
    .line_adv_o   (line_adv_o),
    .frame_o      (frame_o),
    .active_o     (active_o)
);

// File: tb/raster_scan_counter_tb.sv
`timescale 1ns/1ps
module raster_scan_counter_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wide = 1'b0, m5 = 1'b1, disp = 1'b1, m4en = 1'b1, region = 1'b0, pal = 1'b0;
    logic [7:0] slot;
    logic [8:0] line;
    logic       adv, frame, active;

    int checks = 0, errors = 0;
    int last_adv_slot = 0, frame_cnt = 0, frame_line = 0;

    always #2.5 clk = ~clk;   // 200 MHz

    raster_scan_counter u_dut (
        .clk(clk), .rst_n(rst_n), .wide_i(wide), .m5_i(m5), .disp_en_i(disp),
        .m4_en_i(m4en), .region_pal_i(region), .pal_i(pal),
        .slot_o(slot), .line_o(line), .line_adv_o(adv), .frame_o(frame), .active_o(active)
    );

    // {m5, disp, m4en, region, pal, expected active} at line 0
    localparam logic [5:0] ACT_VEC [8] = '{
        6'b11000_1, 6'b10100_0, 6'b01100_1, 6'b01000_0,
        6'b00110_0, 6'b11011_1, 6'b11001_1, 6'b01110_1
    };

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    task automatic adv_lines(input int n);
        int seen;
        seen = 0;
        frame_cnt = 0;
        while (seen < n) begin
            @(negedge clk);
            if (frame) begin frame_cnt++; frame_line = int'(line); end
            if (adv) begin seen++; last_adv_slot = int'(slot); end
        end
    endtask

    task automatic to_slot(input int s);
        while (int'(slot) != s) @(negedge clk);
    endtask

    initial begin
        #(190000 * 5);
        errors++;
        $display("FAIL watchdog: actual hung, expected completion");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 slot", int'(slot), 0);
        check("R1 line", int'(line), 0);
        check("R1 adv", int'(adv), 0);
        check("R1 frame", int'(frame), 0);

        // Activity rule at line 0, counters held in reset
        for (int i = 0; i < 8; i++) begin
            {m5, disp, m4en, region, pal} = ACT_VEC[i][5:1];
            #0.2;
            check(ACT_VEC[i][5] ? "R10 active vector" : "R11 active vector",
                  int'(active), int'(ACT_VEC[i][0]));
        end

        // Wide sequence
        @(negedge clk);
        wide = 1'b1; m5 = 1'b1; disp = 1'b1; m4en = 1'b1; region = 1'b0; pal = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        check("R2 first step", int'(slot), 1);
        adv_lines(1);
        check("R5 wide lc slot", last_adv_slot, 165);
        check("R5 line after strobe", int'(line), 1);
        to_slot(183);
        @(negedge clk);
        check("R3 wide skip", int'(slot), 229);
        to_slot(255);
        @(negedge clk);
        check("R2 slot wrap", int'(slot), 0);

        // Narrow, mode 5, 60 Hz
        rst_n = 1'b0; wide = 1'b0;
        repeat (2) @(negedge clk);
        check("R1 reset line", int'(line), 0);
        rst_n = 1'b1;
        adv_lines(1);
        check("R5 narrow lc slot", last_adv_slot, 133);
        to_slot(148);
        @(negedge clk);
        check("R4 narrow skip", int'(slot), 233);
        adv_lines(222);
        check("R5 line count", int'(line), 223);
        check("R10 active before blank", int'(active), 1);
        adv_lines(1);
        check("R12 frame count", frame_cnt, 1);
        check("R12 frame line", frame_line, 224);
        check("R10 active in blank", int'(active), 0);
        @(negedge clk);
        check("R12 frame one cycle", int'(frame), 0);
        adv_lines(10);
        check("R7 pre-jump line", int'(line), 'h0EA);
        adv_lines(1);
        check("R7 jump target", int'(line), 'h1E5);
        adv_lines(26);
        check("R10 line 1FF", int'(line), 'h1FF);
        check("R10 active at 1FF", int'(active), 1);
        adv_lines(1);
        check("R6 wrap", int'(line), 0);

        // Mode 5, 50 Hz region, 30-row
        region = 1'b1; pal = 1'b1;
        adv_lines(235);
        check("R8 passes 0EA", int'(line), 235);
        check("R10 no blank at 224", frame_cnt, 0);
        adv_lines(5);
        check("R12 frame at 240", frame_cnt, 1);
        check("R10 blank line 240", frame_line, 240);
        adv_lines(27);
        check("R8 pre-jump line", int'(line), 'h10B);
        adv_lines(1);
        check("R8 jump target", int'(line), 'h1D2);
        adv_lines(45);
        check("R8 reach 1FF", int'(line), 'h1FF);
        adv_lines(1);
        check("R6 wrap 50Hz", int'(line), 0);

        // Mode 4, 60 Hz
        m5 = 1'b0; region = 1'b0; pal = 1'b0;
        #0.2;
        check("R11 active m4 on", int'(active), 1);
        m4en = 1'b0;
        #0.2;
        check("R11 active m4 off", int'(active), 0);
        m4en = 1'b1;
        adv_lines(192);
        check("R5 mode4 lc slot", last_adv_slot, 249);
        check("R11 frame line", frame_line, 192);
        check("R12 frame count m4", frame_cnt, 1);
        check("R11 active blank", int'(active), 0);
        adv_lines(27);
        check("R9 pre-jump line", int'(line), 'h0DB);
        adv_lines(1);
        check("R9 jump target", int'(line), 'h1D5);

        summary();
    end
endmodule